// File: doc/BRIEF.md
# SIMD Floating-Point Exception Controller

This block sits beside a packed or scalar SIMD floating-point execution unit and handles what happens to the exception conditions that the lanes detect. When an instruction completes, the unit pulses a completion strobe together with a six-bit condition vector for every lane and a lane-active mask. The controller ORs the conditions of the active lanes and folds the result into six sticky status flags. It compares the same conditions with six mask bits. If any condition is unmasked, it issues exactly one fault pulse.

The fault type is chosen by an operating-system support enable, taken from bit 10 of a system control word. When that bit is set, an unmasked condition raises the dedicated SIMD floating-point fault. When it is clear, the same event raises an invalid-opcode fault instead. The six classes are invalid operation, denormal operand, divide-by-zero, overflow, underflow and inexact result. Denormal operand is a class that IEEE 754 does not define.

Software loads the whole control/status word through a load port and reads it back at any time through a read port. The arithmetic that detects conditions, the masked default results and the handler entry all live outside this block.

Top module: `simd_fpx_ctrl`

## Requirements
- R1: After reset the control/status word reads 0x1F80 (all six masks set, all flags clear) and neither fault output is asserted.
- R2: Class order inside each six-bit group is invalid (bit 0), denormal (1), divide-by-zero (2), overflow (3), underflow (4), inexact (5). Lane n owns condition bits [6n+5:6n]. On a completion strobe, each flag is set by the OR of its class over the lanes whose active bit is 1. Inactive lanes have no effect.
- R3: Flags are sticky. A completion with no conditions, or a cycle without strobe or load, leaves the word unchanged.
- R4: A load writes flags from data bits 5:0 and masks from bits 12:7, visible on the read port the next cycle. Bits 6 and 15:13 always read zero.
- R5: When a completing instruction raises a condition whose mask is clear and the OS-support bit is 1, the SIMD fault output is high for exactly the one cycle after the strobe.
- R6: Under the same event with the OS-support bit at 0, the invalid-opcode fault pulses instead and the SIMD fault stays low.
- R7: Conditions whose masks are set only update the flags and raise no fault.
- R8: At most one fault output is high in any cycle. A fault appears only in the cycle after a completion strobe; conditions presented without a strobe are ignored.
- R9: When a load and a completion fall in the same cycle, the load is applied first. The completion's conditions are ORed into the loaded flags, and the loaded masks decide whether a fault is raised.
- R10: Only bit 10 of the system control word selects the fault type; its other bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| done_i | input | 1 | Instruction-completion strobe |
| lane_act_i | input | LANES | Per-lane active mask for the completing instruction |
| lane_cond_i | input | 6*LANES | Per-lane exception conditions, six bits per lane |
| csr_ld_i | input | 1 | Load strobe for the control/status word |
| csr_wdata_i | input | 16 | Data for the load |
| csr_rdata_o | output | 16 | Current control/status word |
| sys_ctl_i | input | 32 | System control word; bit 10 is the OS-support enable |
| simd_fault_o | output | 1 | SIMD floating-point fault pulse |
| undef_fault_o | output | 1 | Invalid-opcode fault pulse |

## Verification
A software load and an instruction completion can land in the same cycle, and this is where the register's ordering matters. The bench drives both strobes on one edge twice. In the first case the loaded word masks every class and clears the flags, and the completion carries an otherwise unmasked divide-by-zero. In the second case the loaded word unmasks everything and the completion carries inexact. It then judges the read-back word, expecting the load's value plus the completion's flag. It also judges the fault outputs, which must follow the loaded masks rather than the previous ones.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

  localparam int NCLS     = 6;
  localparam int CSR_W    = 16;
  localparam int FLAG_LSB = 0;
  localparam int MASK_LSB = 7;

  typedef logic [NCLS-1:0] cls_vec_t;

  typedef enum logic [2:0] {
    CLS_INVALID  = 3'd0,
    CLS_DENORMAL = 3'd1,
    CLS_DIVZERO  = 3'd2,
    CLS_OVERFLOW = 3'd3,
    CLS_UNDERFLW = 3'd4,
    CLS_INEXACT  = 3'd5
  } cls_idx_e;

  typedef enum logic [1:0] {
    ROUTE_NONE  = 2'd0,
    ROUTE_SIMD  = 2'd1,
    ROUTE_UNDEF = 2'd2
  } fault_route_e;

  // Assemble the visible word; reserved bits read zero.
  function automatic logic [CSR_W-1:0] csr_pack(input cls_vec_t flags, input cls_vec_t masks);
    logic [CSR_W-1:0] w;
    w = '0;
    w[FLAG_LSB +: NCLS] = flags;
    w[MASK_LSB +: NCLS] = masks;
    return w;
  endfunction

  // Decide the fault kind for one completing instruction.
  function automatic fault_route_e route_fault(input logic done, input cls_vec_t cond,
                                               input cls_vec_t masks, input logic os_en);
    if (!done || ((cond & ~masks) == '0)) return ROUTE_NONE;
    return os_en ? ROUTE_SIMD : ROUTE_UNDEF;
  endfunction

endpackage

// File: rtl/fpx_lane_merge.sv
module fpx_lane_merge
  import fpx_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0]      lane_act,
  input  logic [LANES*NCLS-1:0] lane_cond,
  output cls_vec_t              cond_any
);

  cls_vec_t gated [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign gated[g] = lane_cond[g*NCLS +: NCLS] & {NCLS{lane_act[g]}};
  end

  always_comb begin
    cond_any = '0;
    for (int l = 0; l < LANES; l++) cond_any = cond_any | gated[l];
  end

endmodule

// File: rtl/fpx_csr.sv
module fpx_csr
  import fpx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [CSR_W-1:0] wdata,
  input  logic             done,
  input  cls_vec_t         cond_any,
  output cls_vec_t         flags,
  output cls_vec_t         masks,
  output cls_vec_t         mask_eff,
  output logic [CSR_W-1:0] rdata
);

  cls_vec_t flag_base, flag_nxt;
  logic     wdata_unused;

  assign wdata_unused = ^wdata;

  // Load first, then merge the completing instruction's conditions.
  assign flag_base = ld ? wdata[FLAG_LSB +: NCLS] : flags;
  assign mask_eff  = ld ? wdata[MASK_LSB +: NCLS] : masks;
  assign flag_nxt  = flag_base | (done ? cond_any : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
      masks <= '1;
    end else begin
      flags <= flag_nxt;
      masks <= mask_eff;
    end
  end

  assign rdata = csr_pack(flags, masks);

  assert_flag_merge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ((flags & $past(cond_any)) == $past(cond_any)));

  assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !done) |=> (flags == $past(flags)) && (masks == $past(masks)));

  assert_load_masks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (masks == $past(wdata[MASK_LSB +: NCLS])));

  assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[CSR_W-1:MASK_LSB+NCLS] == '0) && (rdata[MASK_LSB-1:FLAG_LSB+NCLS] == '0));

endmodule

// File: rtl/fpx_fault_sel.sv
module fpx_fault_sel
  import fpx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     done,
  input  cls_vec_t cond_any,
  input  cls_vec_t mask_eff,
  input  logic     os_en,
  output logic     simd_fault,
  output logic     undef_fault
);

  fault_route_e route;
  logic         unmasked_hit;

  assign route        = route_fault(done, cond_any, mask_eff, os_en);
  assign unmasked_hit = (route != ROUTE_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      simd_fault  <= 1'b0;
      undef_fault <= 1'b0;
    end else begin
      simd_fault  <= (route == ROUTE_SIMD);
      undef_fault <= (route == ROUTE_UNDEF);
    end
  end

  assert_simd_needs_os_R5: assert property (@(posedge clk) disable iff (!rst_n)
    simd_fault |-> $past(os_en));

  assert_undef_without_os_R6: assert property (@(posedge clk) disable iff (!rst_n)
    undef_fault |-> !$past(os_en));

  assert_masked_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ((cond_any & ~mask_eff) == '0)) |=> !simd_fault && !undef_fault);

  assert_one_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({simd_fault, undef_fault}));

  assert_fault_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (simd_fault || undef_fault) |-> $past(done));

  assert_hit_reported_R5: assert property (@(posedge clk) disable iff (!rst_n)
    unmasked_hit |=> (simd_fault || undef_fault));

endmodule

// File: rtl/simd_fpx_ctrl.sv
module simd_fpx_ctrl
  import fpx_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int CTL_W  = 32,
  parameter int OS_BIT = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  done_i,
  input  logic [LANES-1:0]      lane_act_i,
  input  logic [LANES*NCLS-1:0] lane_cond_i,
  input  logic                  csr_ld_i,
  input  logic [CSR_W-1:0]      csr_wdata_i,
  output logic [CSR_W-1:0]      csr_rdata_o,
  input  logic [CTL_W-1:0]      sys_ctl_i,
  output logic                  simd_fault_o,
  output logic                  undef_fault_o
);

  cls_vec_t cond_any, flags, masks, mask_eff;
  logic     os_en;
  logic     ctl_unused;

  assign os_en      = sys_ctl_i[OS_BIT];
  assign ctl_unused = ^sys_ctl_i;

  fpx_lane_merge #(.LANES(LANES)) u_merge (
    .lane_act  (lane_act_i),
    .lane_cond (lane_cond_i),
    .cond_any  (cond_any)
  );

  fpx_csr u_csr (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld       (csr_ld_i),
    .wdata    (csr_wdata_i),
    .done     (done_i),
    .cond_any (cond_any),
    .flags    (flags),
    .masks    (masks),
    .mask_eff (mask_eff),
    .rdata    (csr_rdata_o)
  );

  fpx_fault_sel u_fault (
    .clk         (clk),
    .rst_n       (rst_n),
    .done        (done_i),
    .cond_any    (cond_any),
    .mask_eff    (mask_eff),
    .os_en       (os_en),
    .simd_fault  (simd_fault_o),
    .undef_fault (undef_fault_o)
  );

  // Loaded masks, not the old ones, govern a coinciding completion.
  assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_ld_i && done_i && ((cond_any & ~csr_wdata_i[MASK_LSB +: NCLS]) == '0))
      |=> !simd_fault_o && !undef_fault_o);

  assert_flags_seen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata_o[FLAG_LSB +: NCLS] == flags && csr_rdata_o[MASK_LSB +: NCLS] == masks);

endmodule

// File: tb/simd_fpx_ctrl_bench.sv
module simd_fpx_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        done_i = 1'b0;
  logic [3:0]  lane_act_i = '0;
  logic [23:0] lane_cond_i = '0;
  logic        csr_ld_i = 1'b0;
  logic [15:0] csr_wdata_i = '0;
  logic [15:0] csr_rdata_o;
  logic [31:0] sys_ctl_i = '0;
  logic        simd_fault_o, undef_fault_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  simd_fpx_ctrl u_simd_fpx_ctrl (
    .clk(clk), .rst_n(rst_n), .done_i(done_i), .lane_act_i(lane_act_i),
    .lane_cond_i(lane_cond_i), .csr_ld_i(csr_ld_i), .csr_wdata_i(csr_wdata_i),
    .csr_rdata_o(csr_rdata_o), .sys_ctl_i(sys_ctl_i),
    .simd_fault_o(simd_fault_o), .undef_fault_o(undef_fault_o)
  );

  // {ld, wdata[16], done, act[4], cond[24], sysctl[32], exp_rd[16], exp_simd, exp_undef}
  localparam int NV = 12;
  localparam logic [95:0] VEC [NV] = '{
    {1'b0, 16'h0000, 1'b1, 4'hF, 24'h010020, 32'h00000400, 16'h1FB0, 1'b0, 1'b0}, // R7 R2
    {1'b1, 16'hFDC0, 1'b0, 4'h0, 24'h000000, 32'h00000400, 16'h1D80, 1'b0, 1'b0}, // R4
    {1'b0, 16'h0000, 1'b1, 4'h1, 24'h000100, 32'h00000400, 16'h1D80, 1'b0, 1'b0}, // R2
    {1'b0, 16'h0000, 1'b1, 4'h2, 24'h000100, 32'h00000400, 16'h1D84, 1'b1, 1'b0}, // R5
    {1'b0, 16'h0000, 1'b0, 4'h0, 24'h000000, 32'h00000400, 16'h1D84, 1'b0, 1'b0}, // R3 R5
    {1'b0, 16'h0000, 1'b1, 4'h8, 24'h100000, 32'hFFFFFBFF, 16'h1D84, 1'b0, 1'b1}, // R6 R10
    {1'b0, 16'h0000, 1'b0, 4'hF, 24'hFFFFFF, 32'h00000400, 16'h1D84, 1'b0, 1'b0}, // R8
    {1'b0, 16'h0000, 1'b1, 4'hF, 24'h000005, 32'h00000400, 16'h1D85, 1'b1, 1'b0}, // R5 R7
    {1'b1, 16'h1F80, 1'b1, 4'h2, 24'h000100, 32'h00000400, 16'h1F84, 1'b0, 1'b0}, // R9
    {1'b1, 16'h0000, 1'b1, 4'h1, 24'h000020, 32'h00000400, 16'h0020, 1'b1, 1'b0}, // R9
    {1'b0, 16'h0000, 1'b1, 4'hF, 24'h000000, 32'h00000400, 16'h0020, 1'b0, 1'b0}, // R3
    {1'b0, 16'h0000, 1'b1, 4'hF, 24'h002000, 32'h00000400, 16'h0022, 1'b1, 1'b0}  // R2 R5
  };

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R7/R2 masked flags";
      1: return "R4 load";
      2: return "R2 inactive lane";
      3: return "R5 simd fault";
      4: return "R3 sticky";
      5: return "R6 undef fault, R10 bit";
      6: return "R8 no strobe";
      7: return "R5 mixed masked";
      8: return "R9 load+done masked";
      9: return "R9 load+done unmasked";
      10: return "R3 empty done";
      default: return "R2 denormal";
    endcase
  endfunction

  task automatic check(input string tag, input logic [17:0] got, input logic [17:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual rd=%h s=%b u=%b expected rd=%h s=%b u=%b",
               tag, got[17:2], got[1], got[0], exp[17:2], exp[1], exp[0]);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", {csr_rdata_o, simd_fault_o, undef_fault_o}, {16'h1F80, 2'b00});
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {csr_rdata_o, simd_fault_o, undef_fault_o}, {16'h1F80, 2'b00});

    for (int i = 0; i < NV; i++) begin
      csr_ld_i    = VEC[i][95];
      csr_wdata_i = VEC[i][94:79];
      done_i      = VEC[i][78];
      lane_act_i  = VEC[i][77:74];
      lane_cond_i = VEC[i][73:50];
      sys_ctl_i   = VEC[i][49:18];
      @(negedge clk);
      check(vec_tag(i), {csr_rdata_o, simd_fault_o, undef_fault_o}, VEC[i][17:0]);
    end

    // R5: the pulse from the last vector lasts one cycle only.
    csr_ld_i = 1'b0; done_i = 1'b0; lane_act_i = '0; lane_cond_i = '0;
    @(negedge clk);
    check("R5 pulse width", {csr_rdata_o, simd_fault_o, undef_fault_o}, {16'h0022, 2'b00});

    // R8: back-to-back undef faults, each one cycle after its strobe.
    sys_ctl_i = 32'h0; done_i = 1'b1; lane_act_i = 4'h4; lane_cond_i = 24'h001000;
    @(negedge clk);
    check("R8 first strobe", {csr_rdata_o, simd_fault_o, undef_fault_o}, {16'h0023, 2'b01});
    done_i = 1'b0;
    @(negedge clk);
    check("R8 after strobe", {csr_rdata_o, simd_fault_o, undef_fault_o}, {16'h0023, 2'b00});

    // R1: reset in mid-run restores the reset word.
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid-run reset", {csr_rdata_o, simd_fault_o, undef_fault_o}, {16'h1F80, 2'b00});
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end

endmodule